// File: doc/BRIEF.md
# Shared-Bus Register Transfer Unit

This block holds a small bank of byte-wide registers that all sit on one common data bus, which carries data both into and out of every register. Each register has two private controls: a capture control, which makes it take in the byte currently on the bus, and a drive control, which gates its stored byte onto the bus. An external byte source with its own drive control lets surrounding logic place values on the same bus.

Sources that are not driving contribute zero, because their outputs pass through AND gating and do not float. The bus is the bitwise OR of every source that is driving. Data moves between registers only by the transfer protocol on the bus:
1. Drive the source register.
2. Pulse the destination's capture control for one clock.
3. Release the source.

Capture is synchronous. On each rising clock edge with its capture control high, a register loads the bus value formed in that same cycle.

Top module: `busxfer_unit`

## Requirements
- R1: An active-high synchronous reset clears every register to 0x00. After reset, driving any single register puts 0x00 on the bus.
- R2: With no drive control high, every bus bit is 0.
- R3: With only the external drive high, the bus equals the external data input in the same cycle, with no clock edge in between.
- R4: On a rising edge with a register's capture control high, the register loads the bus value present in that cycle. A one-cycle pulse stores exactly one value.
- R5: On an edge with its capture control low, a register keeps its value, whatever the bus carries.
- R6: A register whose drive control is high and which is the only source shows its stored byte on the bus. With its drive control low it contributes all zeros.
- R7: Driving register A, pulsing B's capture control for one cycle and then releasing A leaves B equal to A, and leaves A unchanged.
- R8: With several sources driving at once, the bus is the bitwise OR of their bytes.
- R9: A register that captures while it is also driving loads the whole merged bus: the OR of its own byte and the bytes of the other active sources.
- R10: Registers that capture on the same edge all load the same bus value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high synchronous reset |
| reg_store | input | NUM_REGS | Capture control, bit k for register k |
| reg_drive | input | NUM_REGS | Drive control, bit k for register k |
| ext_data | input | DATA_W | External byte source |
| ext_drive | input | 1 | Gates ext_data onto the bus |
| bus_o | output | DATA_W | Merged shared bus |

## Verification
The bus output is combinational from the drive controls and the stored bytes. A bus check therefore samples one time unit after the inputs change at the falling edge, before any rising edge occurs.

A capture takes effect at the rising edge after the falling edge that raised the capture control. The bench clears the control at the next falling edge and reads the register back there. It reads a register by driving that register alone, so every stored value is observed only through the bus.

Hold behaviour is checked by keeping a different value on the bus for several edges with capture low, and then reading the register back.

// File: rtl/busxfer_pkg.sv
package busxfer_pkg;
   // How the bus merges its sources.
   typedef enum logic [0:0] {
      MERGE_CHAIN = 1'b0,
      MERGE_TREE  = 1'b1
   } merge_style_e;

   localparam int unsigned DEFAULT_DATA_W   = 8;
   localparam int unsigned DEFAULT_NUM_REGS = 4;
endpackage

// File: rtl/busxfer_store_reg.sv
module busxfer_store_reg #(
   parameter int unsigned    DATA_W  = 8,
   parameter logic [DATA_W-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              store_i,
   input  logic [DATA_W-1:0] d_i,
   output logic [DATA_W-1:0] q_o
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("busxfer_store_reg: DATA_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         q_o <= RST_VAL;
      end else if (store_i) begin
         q_o <= d_i;
      end
   end
endmodule

// File: rtl/busxfer_gate.sv
module busxfer_gate #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              en_i,
   input  logic [DATA_W-1:0] d_i,
   output logic [DATA_W-1:0] q_o
);
   // Per-bit AND gating: a disabled source drives zeros.
   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         assign q_o[b] = d_i[b] & en_i;
      end
   endgenerate
endmodule

// File: rtl/busxfer_merge.sv
module busxfer_merge
   import busxfer_pkg::*;
#(
   parameter int unsigned  DATA_W  = 8,
   parameter int unsigned  NUM_SRC = 5,
   parameter merge_style_e STYLE   = MERGE_TREE
) (
   input  logic [NUM_SRC*DATA_W-1:0] src_i,
   output logic [DATA_W-1:0]         bus_o
);
   localparam int unsigned LVLS   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam int unsigned LEAVES = 1 << LVLS;
   localparam int unsigned NODES  = 2 * LEAVES - 1;

   generate
      if (NUM_SRC < 1) begin : g_bad_src
         $error("busxfer_merge: NUM_SRC must be at least 1");
      end

      if (STYLE == MERGE_CHAIN) begin : g_chain
         always_comb begin
            bus_o = '0;
            for (int i = 0; i < NUM_SRC; i++) begin
               bus_o = bus_o | src_i[i*DATA_W +: DATA_W];
            end
         end
      end else begin : g_tree
         // Heap-ordered OR tree: node 0 is the root, node n has children 2n+1 and 2n+2.
         logic [DATA_W-1:0] node [NODES];
         for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
            if (l < NUM_SRC) begin : g_real
               assign node[LEAVES-1+l] = src_i[l*DATA_W +: DATA_W];
            end else begin : g_pad
               assign node[LEAVES-1+l] = '0;
            end
         end
         for (genvar n = 0; n < LEAVES - 1; n++) begin : g_inner
            assign node[n] = node[2*n+1] | node[2*n+2];
         end
         assign bus_o = node[0];
      end
   endgenerate
endmodule

// File: rtl/busxfer_unit.sv
module busxfer_unit
   import busxfer_pkg::*;
#(
   parameter int unsigned  DATA_W   = DEFAULT_DATA_W,
   parameter int unsigned  NUM_REGS = DEFAULT_NUM_REGS,
   parameter merge_style_e MERGE    = MERGE_TREE
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_REGS-1:0] reg_store,
   input  logic [NUM_REGS-1:0] reg_drive,
   input  logic [DATA_W-1:0]   ext_data,
   input  logic                ext_drive,
   output logic [DATA_W-1:0]   bus_o
);
   localparam int unsigned NUM_SRC = NUM_REGS + 1;
   localparam int unsigned EXT_LSB = NUM_REGS * DATA_W;

   generate
      if (NUM_REGS < 3) begin : g_bad_regs
         $error("busxfer_unit: NUM_REGS must be at least 3");
      end
   endgenerate

   logic [NUM_REGS*DATA_W-1:0] q_flat;
   logic [NUM_SRC*DATA_W-1:0]  src_flat;

   generate
      for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
         busxfer_store_reg #(.DATA_W(DATA_W)) u_store (
            .clk     (clk),
            .rst     (rst),
            .store_i (reg_store[k]),
            .d_i     (bus_o),
            .q_o     (q_flat[k*DATA_W +: DATA_W])
         );
         busxfer_gate #(.DATA_W(DATA_W)) u_gate (
            .en_i (reg_drive[k]),
            .d_i  (q_flat[k*DATA_W +: DATA_W]),
            .q_o  (src_flat[k*DATA_W +: DATA_W])
         );
      end
   endgenerate

   busxfer_gate #(.DATA_W(DATA_W)) u_ext_gate (
      .en_i (ext_drive),
      .d_i  (ext_data),
      .q_o  (src_flat[EXT_LSB +: DATA_W])
   );

   busxfer_merge #(
      .DATA_W  (DATA_W),
      .NUM_SRC (NUM_SRC),
      .STYLE   (MERGE)
   ) u_merge (
      .src_i (src_flat),
      .bus_o (bus_o)
   );
endmodule

// File: rtl/busxfer_unit_chk.sv
module busxfer_unit_chk #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned NUM_REGS = 4
) (
   input logic                       clk,
   input logic                       rst,
   input logic [NUM_REGS-1:0]        reg_store,
   input logic [NUM_REGS-1:0]        reg_drive,
   input logic [DATA_W-1:0]          ext_data,
   input logic                       ext_drive,
   input logic [DATA_W-1:0]          bus_o,
   input logic [NUM_REGS*DATA_W-1:0] q_flat
);
   p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
      (reg_drive == '0 && !ext_drive) |-> bus_o == '0);

   p_ext_pass_r3: assert property (@(posedge clk) disable iff (rst)
      (reg_drive == '0 && ext_drive) |-> bus_o == ext_data);

   generate
      for (genvar k = 0; k < NUM_REGS; k++) begin : g_chk
         p_reset_clear_r1: assert property (@(posedge clk)
            rst |=> q_flat[k*DATA_W +: DATA_W] == '0);

         p_capture_r4: assert property (@(posedge clk) disable iff (rst)
            reg_store[k] |=> q_flat[k*DATA_W +: DATA_W] == $past(bus_o));

         p_hold_r5: assert property (@(posedge clk) disable iff (rst)
            !reg_store[k] |=> $stable(q_flat[k*DATA_W +: DATA_W]));

         p_drive_shows_r6: assert property (@(posedge clk) disable iff (rst)
            (reg_drive == (NUM_REGS'(1) << k) && !ext_drive)
               |-> bus_o == q_flat[k*DATA_W +: DATA_W]);
      end
   endgenerate
endmodule

bind busxfer_unit busxfer_unit_chk #(
   .DATA_W   (DATA_W),
   .NUM_REGS (NUM_REGS)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .reg_store (reg_store),
   .reg_drive (reg_drive),
   .ext_data  (ext_data),
   .ext_drive (ext_drive),
   .bus_o     (bus_o),
   .q_flat    (q_flat)
);

// File: tb/busxfer_unit_tb_top.sv
`timescale 1ns/1ps
module busxfer_unit_tb_top;
   localparam int W  = 8;
   localparam int NR = 4;

   logic          clk = 1'b0;
   logic          rst;
   logic [NR-1:0] reg_store;
   logic [NR-1:0] reg_drive;
   logic [W-1:0]  ext_data;
   logic          ext_drive;
   logic [W-1:0]  bus_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   busxfer_unit #(.DATA_W(W), .NUM_REGS(NR)) dut_i (
      .clk       (clk),
      .rst       (rst),
      .reg_store (reg_store),
      .reg_drive (reg_drive),
      .ext_data  (ext_data),
      .ext_drive (ext_drive),
      .bus_o     (bus_o)
   );

   task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      reg_store = '0;
      reg_drive = '0;
      ext_drive = 1'b0;
      ext_data  = '0;
   endtask

   // Read register k through the bus by driving it alone.
   task automatic peek(input int k, input logic [W-1:0] exp, input string req);
      @(negedge clk);
      idle_inputs();
      reg_drive[k] = 1'b1;
      #1;
      check(bus_o, exp, req);
      reg_drive = '0;
   endtask

   task automatic load(input int k, input logic [W-1:0] val);
      @(negedge clk);
      idle_inputs();
      ext_data     = val;
      ext_drive    = 1'b1;
      reg_store[k] = 1'b1;
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic t_reset();
      for (int k = 0; k < NR; k++) peek(k, 8'h00, "R1 reset clears");
      @(negedge clk);
      idle_inputs();
      #1;
      check(bus_o, 8'h00, "R2 idle bus");
   endtask

   task automatic t_ext();
      @(negedge clk);
      idle_inputs();
      ext_data  = 8'h5A;
      ext_drive = 1'b1;
      #1;
      check(bus_o, 8'h5A, "R3 external drive");
      ext_drive = 1'b0;
      #1;
      check(bus_o, 8'h00, "R2 external gated off");
   endtask

   task automatic t_store();
      load(0, 8'hA5);
      peek(0, 8'hA5, "R4 capture reg0");
      load(1, 8'h3C);
      peek(1, 8'h3C, "R4 capture reg1");
   endtask

   task automatic t_hold();
      @(negedge clk);
      idle_inputs();
      ext_data  = 8'hFF;
      ext_drive = 1'b1;
      repeat (4) @(negedge clk);
      idle_inputs();
      peek(0, 8'hA5, "R5 hold reg0");
      peek(1, 8'h3C, "R5 hold reg1");
   endtask

   task automatic t_gate();
      peek(0, 8'hA5, "R6 drive reg0");
      @(negedge clk);
      idle_inputs();
      #1;
      check(bus_o, 8'h00, "R6 drive off gives zero");
   endtask

   task automatic t_copy();
      @(negedge clk);
      idle_inputs();
      reg_drive[0] = 1'b1;
      @(negedge clk);
      reg_store[2] = 1'b1;
      @(negedge clk);
      reg_store[2] = 1'b0;
      @(negedge clk);
      reg_drive[0] = 1'b0;
      peek(2, 8'hA5, "R7 copy destination");
      peek(0, 8'hA5, "R7 copy source kept");
   endtask

   task automatic t_merge();
      @(negedge clk);
      idle_inputs();
      reg_drive[0] = 1'b1;
      reg_drive[1] = 1'b1;
      #1;
      check(bus_o, 8'hBD, "R8 OR of two registers");
      ext_data  = 8'h42;
      ext_drive = 1'b1;
      #1;
      check(bus_o, 8'hFF, "R8 OR of three sources");
      idle_inputs();
   endtask

   task automatic t_self();
      @(negedge clk);
      idle_inputs();
      reg_drive[1] = 1'b1;
      ext_data     = 8'h41;
      ext_drive    = 1'b1;
      reg_store[1] = 1'b1;
      @(negedge clk);
      idle_inputs();
      peek(1, 8'h7D, "R9 capture while driving");
   endtask

   task automatic t_broadcast();
      @(negedge clk);
      idle_inputs();
      ext_data     = 8'h96;
      ext_drive    = 1'b1;
      reg_store[2] = 1'b1;
      reg_store[3] = 1'b1;
      @(negedge clk);
      idle_inputs();
      peek(2, 8'h96, "R10 broadcast reg2");
      peek(3, 8'h96, "R10 broadcast reg3");
      peek(0, 8'hA5, "R5 untouched reg0");
   endtask

   task automatic t_reset_mid();
      @(negedge clk);
      idle_inputs();
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      for (int k = 0; k < NR; k++) peek(k, 8'h00, "R1 reset after use");
   endtask

   initial begin
      rst = 1'b1;
      idle_inputs();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_ext();
      t_store();
      t_hold();
      t_gate();
      t_copy();
      t_merge();
      t_self();
      t_broadcast();
      t_reset_mid();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule